// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation converter. It holds a small configuration word with six fields:

- a conversion enable;
- a resolution selector;
- a read-back format bit;
- a reference-burst bit;
- a power-mode selector;
- a sticky flag for an unsupported configuration.

An accepted start pulse launches a sample-and-convert sequence. The sequence lasts 9, 11, 14 or 16 clock cycles, depending on the resolution captured when the start is accepted.

While a sequence runs, the block raises a busy flag and may enable the reference buffer. On the last cycle of the sequence it drops busy and pulses a one-cycle valid strobe. The raw comparator word is masked to the active resolution and stored right-aligned as an unsigned value. At read time the stored value is shown in one of two forms:

- right-aligned unsigned;
- left-aligned two's complement, with the unused low bits reading as zero.

The resolution, burst and power fields can only be changed while the enable bit is clear. This protects a running configuration from stray writes.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 7'h06. The layout is en at bit 0, res at bits 2:1 = 2'b11, fmt at bit 3, burst at bit 4 and pwr at bits 6:5, all other fields 0. In the same state `busy`, `res_valid` and `cfg_err` are 0, `ref_en` is 1 and `rd_data` is 0.
- R2: A start is accepted when `start`=1, en=1 and `busy`=0, at that clock edge. It is followed by L cycles: `busy` is high for the first L-1 and `res_valid` is high for exactly the last one, with `busy` low there. L is 9, 11, 14 or 16 for res 2'b00, 2'b01, 2'b10 or 2'b11.
- R3: A start pulse is ignored while `busy`=1 or en=0. A start in the valid cycle is accepted.
- R4: A write (`cfg_we`=1) updates res, burst and pwr only if en was 0 before that write. Otherwise those fields keep their value.
- R5: The en and fmt fields are written on every `cfg_we`, whatever the state of en.
- R6: With fmt=0, `rd_data` is the stored N-bit result, zero-extended to 16 bits (0000h to 3FFFh at 14 bits).
- R7: With fmt=1, `rd_data` is the stored result shifted to bits 15 down to 16-N, with bit 15 inverted and the lower bits zero. At 14 bits, 0 reads 8000h and 3FFFh reads 7FFCh.
- R8: With burst=0, `ref_en` is 1 at all times. With burst=1, `ref_en` is 1 only on the L cycles of a conversion.
- R9: `cfg_err` becomes 1 on the cycle after the register holds pwr=2'b10 together with res=2'b11. It stays 1 until reset, and conversions still run.
- R10: A conversion uses the resolution captured when its start was accepted, for its length, its mask (raw bits at and above N are dropped) and its read format. This holds even if res is rewritten mid-conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write word {pwr, burst, fmt, res, en} |
| start | input | 1 | Start-of-conversion pulse |
| raw_result | input | 14 | Right-aligned raw word from the comparator stub |
| cfg_rdata | output | 7 | Current configuration word |
| busy | output | 1 | Conversion in progress (excluding final cycle) |
| res_valid | output | 1 | One-cycle strobe on the final conversion cycle |
| ref_en | output | 1 | Reference buffer enable |
| cfg_err | output | 1 | Sticky unsupported-configuration flag |
| rd_data | output | 16 | Formatted read-back of the last result |

## Verification
The hardest case to reach from the ports is a conversion that finishes under a resolution different from the one in the register. The lock only holds while enabled, so the stimulus starts a 12-bit conversion, clears enable mid-flight, and rewrites the resolution to 14 bits before completion. It then checks the length, the mask and the alignment of the result. Two other corners are driven on purpose: a start placed exactly on the valid cycle, and a second start landing a few cycles into a running conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RAW_W = 14;
  localparam int RD_W  = 16;
  localparam int CNT_W = 5;
  localparam int NRES  = 4;
  localparam int CFG_W = 7;

  typedef enum logic [1:0] {RES_8 = 2'b00, RES_10 = 2'b01, RES_12 = 2'b10, RES_14 = 2'b11} res_e;

  localparam logic [1:0] PWR_LOW = 2'b10;

  typedef struct packed {
    logic [1:0] pwr;
    logic       burst;
    logic       fmt;
    res_e       res;
    logic       en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{pwr: 2'b00, burst: 1'b0, fmt: 1'b0, res: RES_14, en: 1'b0};

  function automatic logic [CNT_W-1:0] conv_cycles(input res_e r);
    case (r)
      RES_8:   conv_cycles = CNT_W'(9);
      RES_10:  conv_cycles = CNT_W'(11);
      RES_12:  conv_cycles = CNT_W'(14);
      default: conv_cycles = CNT_W'(16);
    endcase
  endfunction

  function automatic logic [RAW_W-1:0] res_mask(input res_e r);
    case (r)
      RES_8:   res_mask = RAW_W'(14'h00FF);
      RES_10:  res_mask = RAW_W'(14'h03FF);
      RES_12:  res_mask = RAW_W'(14'h0FFF);
      default: res_mask = RAW_W'(14'h3FFF);
    endcase
  endfunction
endpackage

// File: rtl/sar_cfg_reg.sv
module sar_cfg_reg
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t cfg_q,
  output logic err_q
);
  cfg_t cfg_d;
  logic err_d;
  logic bad_combo;

  assign bad_combo = (cfg_q.pwr == PWR_LOW) && (cfg_q.res == RES_14);

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q | bad_combo;
    if (we) begin
      cfg_d.en  = wdata.en;
      cfg_d.fmt = wdata.fmt;
      if (!cfg_q.en) begin
        cfg_d.res   = wdata.res;
        cfg_d.burst = wdata.burst;
        cfg_d.pwr   = wdata.pwr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      err_q <= 1'b0;
    end else begin
      if (we) cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  res_e             res,
  input  logic [RAW_W-1:0] raw,
  output logic             busy,
  output logic             valid,
  output logic             active,
  output res_e             cres_q,
  output logic [RAW_W-1:0] result_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             capture;

  assign busy    = cnt_q > CNT_W'(1);
  assign valid   = cnt_q == CNT_W'(1);
  assign active  = cnt_q != '0;
  assign accept  = start && en && !busy;
  assign capture = cnt_q == CNT_W'(2);

  always_comb begin
    if (accept)      cnt_d = conv_cycles(res);
    else if (active) cnt_d = cnt_q - CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cres_q   <= RES_14;
      result_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (accept)  cres_q   <= res;
      if (capture) result_q <= raw & res_mask(cres_q);
    end
  end
endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt
  import sar_pkg::*;
(
  input  logic [RAW_W-1:0] result,
  input  res_e             cres,
  input  logic             fmt,
  output logic [RD_W-1:0]  rd_data
);
  logic [RD_W-1:0] aligned [NRES];

  for (genvar g = 0; g < NRES; g++) begin : g_align
    localparam int N  = 8 + 2 * g;
    localparam int SH = RD_W - N;
    assign aligned[g] = {~result[N-1], result[N-2:0], {SH{1'b0}}};
  end

  always_comb begin
    if (fmt) rd_data = aligned[cres];
    else     rd_data = {{(RD_W-RAW_W){1'b0}}, result};
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               start,
  input  logic [RAW_W-1:0]   raw_result,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic               busy,
  output logic               res_valid,
  output logic               ref_en,
  output logic               cfg_err,
  output logic [RD_W-1:0]    rd_data
);
  cfg_t             cfg;
  logic             active;
  res_e             cres;
  logic [RAW_W-1:0] result;

  sar_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_t'(cfg_wdata)),
    .cfg_q (cfg),
    .err_q (cfg_err)
  );

  sar_conv_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .en       (cfg.en),
    .res      (cfg.res),
    .raw      (raw_result),
    .busy     (busy),
    .valid    (res_valid),
    .active   (active),
    .cres_q   (cres),
    .result_q (result)
  );

  sar_result_fmt u_fmt (
    .result  (result),
    .cres    (cres),
    .fmt     (cfg.fmt),
    .rd_data (rd_data)
  );

  assign cfg_rdata = cfg;
  assign ref_en    = !cfg.burst || active;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [6:0]  cfg_rdata,
  input logic        busy,
  input logic        res_valid,
  input logic        ref_en,
  input logic        cfg_err,
  input logic [15:0] rd_data
);
  assert_busy_valid_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && res_valid));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_rdata[0] && !busy) |=> busy);

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || res_valid));

  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] |=> ($stable(cfg_rdata[6:4]) && $stable(cfg_rdata[2:1])));

  assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3] |-> (rd_data[1:0] == 2'b00));

  assert_ref_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[4] |-> ref_en);

  assert_ref_in_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || res_valid) |-> ref_en);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[6:5] == 2'b10 && cfg_rdata[2:1] == 2'b11) |=> cfg_err);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cfg_rdata (cfg_rdata),
  .busy      (busy),
  .res_valid (res_valid),
  .ref_en    (ref_en),
  .cfg_err   (cfg_err),
  .rd_data   (rd_data)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_wdata;
  logic        start;
  logic [13:0] raw_result;
  logic [6:0]  cfg_rdata;
  logic        busy, res_valid, ref_en, cfg_err;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string scen = "reset";

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .raw_result(raw_result), .cfg_rdata(cfg_rdata),
    .busy(busy), .res_valid(res_valid), .ref_en(ref_en),
    .cfg_err(cfg_err), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  int m_en, m_res, m_fmt, m_burst, m_pwr, m_err;
  int m_rem, m_cres, m_result;

  function automatic int len_of(int r);
    case (r)
      0: return 9;
      1: return 11;
      2: return 14;
      default: return 16;
    endcase
  endfunction

  function automatic int bits_of(int r);
    return 8 + 2 * r;
  endfunction

  function automatic int model_rd();
    int n;
    n = bits_of(m_cres);
    if (m_fmt == 0) return m_result;
    return ((m_result << (16 - n)) ^ 32'h8000) & 32'hFFFF;
  endfunction

  function automatic logic [6:0] mkcfg(int en, int res, int fmt, int burst, int pwr);
    return {pwr[1:0], burst[0], fmt[0], res[1:0], en[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_res = 3; m_fmt = 0; m_burst = 0; m_pwr = 0; m_err = 0;
      m_rem = 0; m_cres = 3; m_result = 0;
    end else begin
      int old_en, old_rem;
      old_en  = m_en;
      old_rem = m_rem;
      if (old_rem == 2) m_result = int'(raw_result) & ((1 << bits_of(m_cres)) - 1);
      if (start && old_en == 1 && old_rem <= 1) begin
        m_rem  = len_of(m_res);
        m_cres = m_res;
      end else if (old_rem != 0) begin
        m_rem = old_rem - 1;
      end
      if (m_pwr == 2 && m_res == 3) m_err = 1;
      if (cfg_we) begin
        m_en  = int'(cfg_wdata[0]);
        m_fmt = int'(cfg_wdata[3]);
        if (old_en == 0) begin
          m_res   = int'(cfg_wdata[2:1]);
          m_burst = int'(cfg_wdata[4]);
          m_pwr   = int'(cfg_wdata[6:5]);
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, scen, $time, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy", int'(busy), int'(m_rem > 1));
      check("R2 res_valid", int'(res_valid), int'(m_rem == 1));
      check("R8 ref_en", int'(ref_en), int'(m_burst == 0 || m_rem != 0));
      check("R9 cfg_err", int'(cfg_err), m_err);
      check("R4 cfg_rdata", int'(cfg_rdata), int'(mkcfg(m_en, m_res, m_fmt, m_burst, m_pwr)));
      check(m_fmt ? "R7 rd_data" : "R6 rd_data", int'(rd_data), model_rd());
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R2 watchdog: actual=%0d cycles expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(logic [6:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pulse start, return cycles until res_valid (exits on valid cycle negedge)
  task automatic run_conv(logic [13:0] raw, output int n);
    raw_result = raw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!res_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; start = 1'b0; raw_result = '0;
    idle(3);
    // R1: reset state
    check("R1 cfg_rdata", int'(cfg_rdata), 32'h06);
    check("R1 busy", int'(busy), 0);
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 ref_en", int'(ref_en), 1);
    check("R1 cfg_err", int'(cfg_err), 0);
    check("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    idle(2);

    // R2/R6/R7: every resolution, both formats, several patterns
    scen = "lengths";
    for (int r = 0; r < 4; r++) begin
      wr(mkcfg(0, r, r % 2, 0, 0));
      wr(mkcfg(1, r, r % 2, 0, 0));
      run_conv(14'h3FFF, n);
      check("R2 length", n, len_of(r));
      idle(2);
      run_conv(14'h0000, n);
      check("R2 length", n, len_of(r));
      idle(1);
      run_conv(14'h2A5C ^ 14'(r * 14'h111), n);
      idle(2);
    end
    // R7 endpoints at 14 bits
    scen = "signed14";
    wr(mkcfg(1, 3, 1, 0, 0));
    run_conv(14'h3FFF, n);
    check("R7 max", int'(rd_data), 32'h7FFC);
    idle(1);
    run_conv(14'h0000, n);
    check("R7 min", int'(rd_data), 32'h8000);
    idle(1);

    // R3: start while busy and start with en=0 are ignored
    scen = "ignore";
    wr(mkcfg(1, 0, 0, 0, 0));
    wr(mkcfg(1, 0, 0, 0, 0));
    wr(mkcfg(0, 0, 0, 0, 0));
    wr(mkcfg(1, 0, 0, 0, 0));
    raw_result = 14'h0055; start = 1'b1;
    @(negedge clk); start = 1'b0;
    idle(3);
    raw_result = 14'h00AA; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 5;
    while (!res_valid && n < 40) begin @(negedge clk); n++; end
    check("R3 second start ignored", n, 9);
    check("R3 result", int'(rd_data), 32'hAA);
    // R3: start on the valid cycle is accepted (back to back)
    run_conv(14'h0012, n);
    check("R3 back-to-back", n, 9);
    idle(2);
    wr(mkcfg(0, 1, 0, 0, 0));
    raw_result = 14'h0033; start = 1'b1;
    @(negedge clk); start = 1'b0;
    idle(2);
    check("R3 en=0 start ignored", int'(busy), 0);

    // R4/R5: lock while enabled; en and fmt still writable
    scen = "lock";
    wr(mkcfg(1, 1, 0, 0, 0));
    wr(mkcfg(1, 3, 1, 1, 2));
    check("R4 res locked", int'(cfg_rdata[2:1]), 1);
    check("R4 burst locked", int'(cfg_rdata[4]), 0);
    check("R5 fmt written", int'(cfg_rdata[3]), 1);
    run_conv(14'h3FFF, n);
    check("R4 length kept", n, 11);
    idle(1);
    wr(mkcfg(0, 1, 0, 0, 0));
    check("R5 en cleared", int'(cfg_rdata[0]), 0);

    // R8: burst mode
    scen = "burst";
    wr(mkcfg(0, 2, 0, 1, 0));
    check("R8 idle off", int'(ref_en), 0);
    wr(mkcfg(1, 2, 0, 1, 0));
    run_conv(14'h1234, n);
    idle(3);
    check("R8 after off", int'(ref_en), 0);

    // R10: resolution rewritten mid-conversion
    scen = "midchange";
    wr(mkcfg(1, 2, 0, 0, 0));
    raw_result = 14'h3ABC; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wr(mkcfg(0, 2, 0, 0, 0));
    wr(mkcfg(0, 3, 0, 0, 0));
    n = 3;
    while (!res_valid && n < 40) begin @(negedge clk); n++; end
    check("R10 length", n, 14);
    check("R10 masked", int'(rd_data), 32'h0ABC);
    wr(mkcfg(0, 3, 1, 0, 0));
    check("R10 aligned", int'(rd_data), 32'h2BC0);

    // R9: low power with 14 bits is flagged but converts
    scen = "cfgerr";
    wr(mkcfg(0, 3, 0, 0, 2));
    idle(1);
    check("R9 flag set", int'(cfg_err), 1);
    wr(mkcfg(1, 3, 0, 0, 2));
    run_conv(14'h2222, n);
    check("R9 converts", n, 16);
    wr(mkcfg(0, 0, 0, 0, 0));
    idle(2);
    check("R9 sticky", int'(cfg_err), 1);

    idle(4);
    summary();
    $finish;
  end
endmodule